// File: doc/BRIEF.md
# Locality Ownership Register Manager

This block holds the locality registers of a command-response buffer front end for a trusted security module. Software writes one-hot commands to a control word. The block decodes each write, tracks whether a locality currently owns the interface, and keeps a small status word. The rest of the interface receives the owning locality number, or a sentinel code when nobody owns it. Reads of the state word also reflect a live "module established" flag that comes from outside the block.

Ownership is held by a two-state machine. The state `OWN_FREE` is entered at reset and on a relinquish command (transition `T_RELEASE`). The state `OWN_HELD` is entered on a request-access command (transition `T_GRANT`). A request while held keeps the machine in `OWN_HELD` (`T_REGRANT`), and a relinquish while free keeps it in `OWN_FREE` (`T_IDLE_RELEASE`). Every other write leaves the machine where it is (`T_HOLD`). Reads are combinational and byte addressed.

Top module: `loc_owner_regs`

## Requirements
- R1: After reset, a read at offset 0x0 (state word) returns 0x80 while `tpm_established` is 1: bit 7 (register-valid) is 1, bit 1 (assigned) is 0, bits 4:2 (locality number) are 0. A read at offset 0x8 (status word) returns 0, and `active_loc` is 0xFF.
- R2: Writing exactly 0x1 to offset 0x4 (control word) requests access. On the next cycle, assigned (state bit 1) and granted (status bit 0) are 1, been-seized (status bit 1) is 0, and `active_loc` equals the locality field, which is 0.
- R3: Writing exactly 0x2 to the control word relinquishes ownership. It clears assigned and granted, and `active_loc` returns to 0xFF. This holds from either state.
- R4: Writing exactly 0x4 (seize) to the control word is decoded but changes no register and no output.
- R5: Writing exactly 0x8 (clear establishment) to the control word is accepted but has no effect.
- R6: A control write whose value is not exactly one of 0x1, 0x2, 0x4, 0x8 (for example 0x0, 0x3, 0x10 or 0x101) has no effect.
- R7: Writes to any offset other than 0x4 have no effect, even when the value is a legal command.
- R8: Bit 0 of a read at offset 0x0 equals the inverse of `tpm_established` at the time of the read.
- R9: A read at a byte offset b within a word returns that 32-bit word shifted right by 8*b bits. The established merge applies only at offset 0x0 exactly, so a read at offset 0x1 returns 0 whatever `tpm_established` is.
- R10: A read of the control word or of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write value |
| rd_addr | input | ADDR_W | Byte offset of the combinational read |
| rd_data | output | DATA_W | Read value |
| tpm_established | input | 1 | Live established flag from the module core |
| active_loc | output | 8 | Owning locality, or 0xFF when none |

## Verification
The command decoder is driven with each of the four legal one-hot values, with zero, with a two-bit value, with a bit above the command field and with a value that has a bit in the upper bytes. These patterns separate an exact-match decoder from one that only tests a single bit. Requests and relinquishes are applied in both machine states, which distinguishes the re-grant and idle-release transitions from the first grant. Reads toggle `tpm_established` at offsets 0x0 and 0x1. This shows that the merge is inverted, that it is live, and that it is tied to the exact offset rather than to the word.

// File: rtl/loc_owner_pkg.sv
package loc_owner_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_REQUEST,
        CMD_RELEASE,
        CMD_SEIZE,
        CMD_CLR_EST
    } loc_cmd_e;

    typedef enum logic {
        OWN_FREE,
        OWN_HELD
    } own_state_e;

    // One-hot command encodings in the control word
    localparam int unsigned CMD_BIT_REQUEST = 0;
    localparam int unsigned CMD_BIT_RELEASE = 1;
    localparam int unsigned CMD_BIT_SEIZE   = 2;
    localparam int unsigned CMD_BIT_CLR_EST = 3;

    // State word field positions
    localparam int unsigned ST_ASSIGNED_BIT = 1;
    localparam int unsigned ST_LOC_LSB      = 2;
    localparam int unsigned ST_VALID_BIT    = 7;

    // Status word field positions
    localparam int unsigned SS_GRANTED_BIT  = 0;
    localparam int unsigned SS_SEIZED_BIT   = 1;

    localparam logic [7:0] LOC_NONE = 8'hFF;

endpackage

// File: rtl/loc_cmd_decode.sv
module loc_cmd_decode
    import loc_owner_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CTRL_OFS = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output loc_cmd_e          cmd
);
    localparam logic [DATA_W-1:0] V_REQUEST = DATA_W'(1) << CMD_BIT_REQUEST;
    localparam logic [DATA_W-1:0] V_RELEASE = DATA_W'(1) << CMD_BIT_RELEASE;
    localparam logic [DATA_W-1:0] V_SEIZE   = DATA_W'(1) << CMD_BIT_SEIZE;
    localparam logic [DATA_W-1:0] V_CLR_EST = DATA_W'(1) << CMD_BIT_CLR_EST;

    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));

    always_comb begin
        cmd = CMD_NONE;
        if (hit) begin
            unique case (wr_data)
                V_REQUEST: cmd = CMD_REQUEST;
                V_RELEASE: cmd = CMD_RELEASE;
                V_SEIZE:   cmd = CMD_SEIZE;
                V_CLR_EST: cmd = CMD_CLR_EST;
                default:   cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/loc_owner_fsm.sv
module loc_owner_fsm
    import loc_owner_pkg::*;
#(
    parameter int unsigned LOC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  loc_cmd_e         cmd,
    output logic             assigned,
    output logic             granted,
    output logic             seized,
    output logic             reg_valid,
    output logic [LOC_W-1:0] loc_num
);
    own_state_e       state_q, state_d;
    logic             granted_q, granted_d;
    logic             seized_q, seized_d;
    logic             valid_q;
    logic [LOC_W-1:0] loc_q;

    // Next-state and status update
    always_comb begin
        state_d   = state_q;
        granted_d = granted_q;
        seized_d  = seized_q;
        unique case (state_q)
            OWN_FREE: begin
                if (cmd == CMD_REQUEST) begin          // T_GRANT
                    state_d   = OWN_HELD;
                    granted_d = 1'b1;
                    seized_d  = 1'b0;
                end else if (cmd == CMD_RELEASE) begin // T_IDLE_RELEASE
                    granted_d = 1'b0;
                end
            end
            OWN_HELD: begin
                if (cmd == CMD_RELEASE) begin          // T_RELEASE
                    state_d   = OWN_FREE;
                    granted_d = 1'b0;
                end else if (cmd == CMD_REQUEST) begin // T_REGRANT
                    granted_d = 1'b1;
                    seized_d  = 1'b0;
                end
            end
            default: state_d = OWN_FREE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= OWN_FREE;
            granted_q <= 1'b0;
            seized_q  <= 1'b0;
            valid_q   <= 1'b1;
            loc_q     <= '0;
        end else begin
            state_q   <= state_d;
            granted_q <= granted_d;
            seized_q  <= seized_d;
        end
    end

    // Outputs
    always_comb begin
        assigned  = (state_q == OWN_HELD);
        granted   = granted_q;
        seized    = seized_q;
        reg_valid = valid_q;
        loc_num   = loc_q;
    end
endmodule

// File: rtl/loc_reg_read.sv
module loc_reg_read
    import loc_owner_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned LOC_W     = 3,
    parameter int unsigned STATE_OFS = 0,
    parameter int unsigned STS_OFS   = 8
) (
    input  logic              [ADDR_W-1:0] rd_addr,
    input  logic                           assigned,
    input  logic                           granted,
    input  logic                           seized,
    input  logic                           reg_valid,
    input  logic              [LOC_W-1:0]  loc_num,
    input  logic                           established,
    output logic              [DATA_W-1:0] rd_data
);
    localparam int unsigned WSEL_W = ADDR_W - 2;

    logic [DATA_W-1:0] state_word, sts_word, word;
    logic [WSEL_W-1:0] wsel;
    logic [1:0]        bsel;

    assign wsel = rd_addr[ADDR_W-1:2];
    assign bsel = rd_addr[1:0];

    always_comb begin
        state_word = '0;
        state_word[ST_ASSIGNED_BIT]                 = assigned;
        state_word[ST_LOC_LSB +: LOC_W]             = loc_num;
        state_word[ST_VALID_BIT]                    = reg_valid;
        sts_word = '0;
        sts_word[SS_GRANTED_BIT] = granted;
        sts_word[SS_SEIZED_BIT]  = seized;
    end

    always_comb begin
        if (wsel == WSEL_W'(STATE_OFS / 4))
            word = state_word;
        else if (wsel == WSEL_W'(STS_OFS / 4))
            word = sts_word;
        else
            word = '0;
        rd_data = word >> (8 * bsel);
        if (rd_addr == ADDR_W'(STATE_OFS))
            rd_data[0] = rd_data[0] | ~established;
    end
endmodule

// File: rtl/loc_owner_regs.sv
module loc_owner_regs
    import loc_owner_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned LOC_W     = 3,
    parameter int unsigned STATE_OFS = 0,
    parameter int unsigned CTRL_OFS  = 4,
    parameter int unsigned STS_OFS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tpm_established,
    output logic [7:0]        active_loc
);
    loc_cmd_e         cmd;
    logic             assigned, granted, seized, reg_valid;
    logic [LOC_W-1:0] loc_num;

    loc_cmd_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS)
    ) i_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cmd(cmd)
    );

    loc_owner_fsm #(.LOC_W(LOC_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .assigned(assigned), .granted(granted), .seized(seized),
        .reg_valid(reg_valid), .loc_num(loc_num)
    );

    loc_reg_read #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOC_W(LOC_W),
        .STATE_OFS(STATE_OFS), .STS_OFS(STS_OFS)
    ) i_rd (
        .rd_addr(rd_addr), .assigned(assigned), .granted(granted),
        .seized(seized), .reg_valid(reg_valid), .loc_num(loc_num),
        .established(tpm_established), .rd_data(rd_data)
    );

    always_comb begin
        active_loc = assigned ? 8'(loc_num) : LOC_NONE;
    end
endmodule

// File: rtl/loc_owner_chk.sv
module loc_owner_chk #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned STATE_OFS = 0,
    parameter int unsigned CTRL_OFS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              tpm_established,
    input logic [7:0]        active_loc
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));

    p_request_owns_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data == DATA_W'(1)) |=> (active_loc != 8'hFF));

    p_release_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data == DATA_W'(2)) |=> (active_loc == 8'hFF));

    p_seize_inert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data == DATA_W'(4)) |=> $stable(active_loc));

    p_clr_est_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data == DATA_W'(8)) |=> $stable(active_loc));

    p_bad_value_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && $countones(wr_data) != 1) |=> $stable(active_loc));

    p_other_addr_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctrl_wr) |=> $stable(active_loc));

    p_est_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(STATE_OFS) && !tpm_established) |-> rd_data[0]);

    p_valid_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(STATE_OFS)) |-> rd_data[7]);
endmodule

bind loc_owner_regs loc_owner_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATE_OFS(STATE_OFS), .CTRL_OFS(CTRL_OFS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tpm_established(tpm_established), .active_loc(active_loc)
);

// File: tb/test_loc_owner_regs.sv
`timescale 1ns/1ps
module test_loc_owner_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tpm_established = 1'b1;
    logic [7:0]  active_loc;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    loc_owner_regs i_loc_owner_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tpm_established(tpm_established), .active_loc(active_loc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'h0, v); check("R1 state", v, 32'h80);
        rd(4'h8, v); check("R1 status", v, 32'h0);
        check("R1 active_loc", {24'h0, active_loc}, 32'hFF);
    endtask

    task automatic t_request;
        logic [31:0] v;
        wr(4'h4, 32'h1);
        rd(4'h0, v); check("R2 state", v, 32'h82);
        rd(4'h8, v); check("R2 status", v, 32'h1);
        check("R2 active_loc", {24'h0, active_loc}, 32'h0);
        wr(4'h4, 32'h1);
        rd(4'h0, v); check("R2 regrant state", v, 32'h82);
    endtask

    task automatic t_release;
        logic [31:0] v;
        wr(4'h4, 32'h2);
        rd(4'h0, v); check("R3 state", v, 32'h80);
        rd(4'h8, v); check("R3 status", v, 32'h0);
        check("R3 active_loc", {24'h0, active_loc}, 32'hFF);
        wr(4'h4, 32'h2);
        rd(4'h0, v); check("R3 idle release", v, 32'h80);
    endtask

    task automatic t_seize;
        logic [31:0] v;
        wr(4'h4, 32'h4);
        rd(4'h0, v); check("R4 seize free", v, 32'h80);
        wr(4'h4, 32'h1);
        wr(4'h4, 32'h4);
        rd(4'h0, v); check("R4 seize held state", v, 32'h82);
        rd(4'h8, v); check("R4 seize held status", v, 32'h1);
    endtask

    task automatic t_clr_est;
        logic [31:0] v;
        wr(4'h4, 32'h8);
        rd(4'h0, v); check("R5 state", v, 32'h82);
        check("R5 active_loc", {24'h0, active_loc}, 32'h0);
    endtask

    task automatic t_bad_values;
        logic [31:0] v;
        wr(4'h4, 32'h3);   rd(4'h0, v); check("R6 0x3", v, 32'h82);
        wr(4'h4, 32'h0);   rd(4'h0, v); check("R6 0x0", v, 32'h82);
        wr(4'h4, 32'h102); rd(4'h0, v); check("R6 0x102", v, 32'h82);
        wr(4'h4, 32'h2);
        wr(4'h4, 32'h10);  rd(4'h0, v); check("R6 0x10", v, 32'h80);
        wr(4'h4, 32'h101); rd(4'h8, v); check("R6 0x101", v, 32'h0);
    endtask

    task automatic t_other_addr;
        logic [31:0] v;
        wr(4'h0, 32'h1); rd(4'h0, v); check("R7 off0", v, 32'h80);
        wr(4'h8, 32'h1); rd(4'h8, v); check("R7 off8", v, 32'h0);
        wr(4'h5, 32'h1);
        check("R7 off5 active_loc", {24'h0, active_loc}, 32'hFF);
    endtask

    task automatic t_established;
        logic [31:0] v;
        tpm_established = 1'b0;
        rd(4'h0, v); check("R8 est=0", v, 32'h81);
        tpm_established = 1'b1;
        rd(4'h0, v); check("R8 est=1", v, 32'h80);
    endtask

    task automatic t_narrow;
        logic [31:0] v;
        wr(4'h4, 32'h1);
        tpm_established = 1'b0;
        rd(4'h1, v); check("R9 state+1", v, 32'h0);
        rd(4'h0, v); check("R9 state+0", v, 32'h83);
        tpm_established = 1'b1;
        rd(4'h9, v); check("R9 status+1", v, 32'h0);
        rd(4'h8, v); check("R9 status+0", v, 32'h1);
    endtask

    task automatic t_ctrl_read;
        logic [31:0] v;
        rd(4'h4, v); check("R10 ctrl", v, 32'h0);
        rd(4'hC, v); check("R10 unmapped", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_request();
        t_release();
        t_seize();
        t_clr_est();
        t_bad_values();
        t_other_addr();
        t_established();
        t_narrow();
        t_ctrl_read();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule